// File: doc/BRIEF.md
# Snooped Write-Back Buffer

This block parks one modified line that the cache has evicted while it services a miss. The victim's line address and data are loaded into the buffer, not written back at once. The miss transaction therefore goes onto the bus first. The buffer asks for the bus for its own write-back only after the cache reports that the miss transaction has completed. That second, separate acquisition uses a request/grant pair, and the line is driven out during the granted cycle.

While the line sits in the buffer, other caches can still reach it. A comparator checks every snooped bus transaction against the buffered line address. When a read or read-exclusive matches, the buffer behaves as the owner of a modified copy: it reports dirty, presents the line data, and discards the entry. Discarding the entry cancels the write-back that was still pending. The buffer holds a single entry, so a further eviction is held off until the entry has left.

The controller has three named states:
- `WB_EMPTY`: no entry.
- `WB_PARKED`: a victim is held and the miss is still in flight.
- `WB_ARBIT`: the bus is being requested for the write-back.

It has these transitions:
- load: `WB_EMPTY` to `WB_PARKED`, when a victim is accepted.
- miss complete: `WB_PARKED` to `WB_ARBIT`.
- write-back granted: `WB_ARBIT` to `WB_EMPTY`.
- snoop hit: `WB_PARKED` or `WB_ARBIT` to `WB_EMPTY`.

Top module: `wbb_top`

## Requirements
- R1: While reset is held and just after it, `vic_ready` is 1 and `bus_req`, `wb_valid` and `snp_dirty` are 0.
- R2: A victim is accepted at a clock edge where `vic_valid` and `vic_ready` are both 1. `vic_ready` is then 0 until the entry leaves. A `vic_valid` while `vic_ready` is 0 changes neither the held address nor the held data.
- R3: `bus_req` stays 0 while a victim is parked. It becomes 1 in the cycle after `miss_done` is sampled in the parked state, and stays 1 until the write-back is granted or the entry is dropped.
- R4: In a cycle where `bus_req` and `bus_gnt` are both 1 and there is no snoop hit, `wb_valid` is 1 and `wb_addr`/`wb_data` carry the victim. In the next cycle the buffer is empty (`vic_ready` = 1, `bus_req` = 0).
- R5: A snoop hit occurs when `snoop_valid` is 1, `snoop_cmd` is 2'b00 (read) or 2'b01 (read-exclusive), an entry is held, and `snoop_addr` equals the held address. In the cycle after the hit, `snp_dirty` is 1 for exactly one cycle, `snp_data` equals the held line, and the entry has been dropped with no write-back.
- R6: A snoop with `snoop_cmd` 2'b10 (another cache's write-back) or 2'b11 (no operation), or a snoop with a different address, causes no response and leaves the entry and its pending write-back unchanged.
- R7: When a snoop hit and a bus grant fall in the same cycle, the snoop wins: `wb_valid` stays 0 and the entry is supplied to the snooper.
- R8: A snoop of any command or address while the buffer is empty causes no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vic_valid | input | 1 | Victim line offered for buffering |
| vic_addr | input | AW | Victim line address |
| vic_data | input | LW | Victim line data |
| vic_ready | output | 1 | Buffer empty; a victim can be accepted |
| miss_done | input | 1 | The miss transaction that caused the eviction has completed |
| bus_req | output | 1 | Bus request for the write-back |
| bus_gnt | input | 1 | Bus grant |
| wb_valid | output | 1 | Write-back transfer in this cycle |
| wb_addr | output | AW | Write-back address |
| wb_data | output | LW | Write-back data |
| snoop_valid | input | 1 | A snooped transaction is on the bus |
| snoop_cmd | input | 2 | 00 read, 01 read-exclusive, 10 write-back, 11 no operation |
| snoop_addr | input | AW | Snooped line address |
| snp_dirty | output | 1 | Buffer holds a modified copy of the snooped line and supplies it |
| snp_data | output | LW | Supplied line data, valid while `snp_dirty` is 1 |

## Verification
The hardest case to reach from the ports is a matching read or read-exclusive that lands in the very cycle the bus grants the write-back. Random stimulus rarely lines these up. A directed sequence therefore parks a victim, completes the miss, and then asserts the grant and a matching snoop together. Random traffic draws snoop and victim addresses from a pool of four, so hits in both the parked and the requesting state occur often. It also mixes in non-responding commands.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
    typedef enum logic [1:0] {
        WB_EMPTY  = 2'd0,
        WB_PARKED = 2'd1,
        WB_ARBIT  = 2'd2
    } wb_state_t;

    typedef enum logic [1:0] {
        SNP_READ   = 2'b00,
        SNP_RDX    = 2'b01,
        SNP_WRBACK = 2'b10,
        SNP_NOP    = 2'b11
    } snp_cmd_t;
endpackage

// File: rtl/wbb_store.sv
module wbb_store #(
    parameter int AW = 32,
    parameter int LW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] vic_addr,
    input  logic [LW-1:0] vic_data,
    output logic [AW-1:0] line_addr,
    output logic [LW-1:0] line_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr <= '0;
            line_data <= '0;
        end else if (load) begin
            line_addr <= vic_addr;
            line_data <= vic_data;
        end
    end
endmodule

// File: rtl/wbb_snoop_cmp.sv
module wbb_snoop_cmp
    import wbb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          entry_valid,
    input  logic          snoop_valid,
    input  logic [1:0]    snoop_cmd,
    input  logic [AW-1:0] snoop_addr,
    input  logic [AW-1:0] line_addr,
    output logic          hit
);
    logic [AW-1:0] bit_eq;
    logic          wants_data;

    for (genvar i = 0; i < AW; i++) begin : g_eq
        assign bit_eq[i] = ~(snoop_addr[i] ^ line_addr[i]);
    end

    always_comb begin
        unique case (snp_cmd_t'(snoop_cmd))
            SNP_READ, SNP_RDX:   wants_data = 1'b1;
            SNP_WRBACK, SNP_NOP: wants_data = 1'b0;
            default:             wants_data = 1'b0;
        endcase
    end

    assign hit = entry_valid & snoop_valid & wants_data & (&bit_eq);
endmodule

// File: rtl/wbb_fsm.sv
module wbb_fsm
    import wbb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vic_valid,
    input  logic      miss_done,
    input  logic      bus_gnt,
    input  logic      snp_hit,
    output wb_state_t state,
    output logic      load,
    output logic      entry_valid,
    output logic      vic_ready,
    output logic      bus_req,
    output logic      wb_fire
);
    wb_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            WB_EMPTY:  if (vic_valid) nxt = WB_PARKED;
            WB_PARKED: if (snp_hit) nxt = WB_EMPTY;
                       else if (miss_done) nxt = WB_ARBIT;
            WB_ARBIT:  if (snp_hit || bus_gnt) nxt = WB_EMPTY;
            default:   nxt = WB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WB_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        vic_ready   = 1'b0;
        bus_req     = 1'b0;
        entry_valid = 1'b0;
        load        = 1'b0;
        wb_fire     = 1'b0;
        unique case (state)
            WB_EMPTY: begin
                vic_ready = 1'b1;
                load      = vic_valid;
            end
            WB_PARKED: entry_valid = 1'b1;
            WB_ARBIT: begin
                entry_valid = 1'b1;
                bus_req     = 1'b1;
                wb_fire     = bus_gnt & ~snp_hit;
            end
            default: vic_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/wbb_top.sv
module wbb_top
    import wbb_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vic_valid,
    input  logic [AW-1:0] vic_addr,
    input  logic [LW-1:0] vic_data,
    output logic          vic_ready,
    input  logic          miss_done,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [LW-1:0] wb_data,
    input  logic          snoop_valid,
    input  logic [1:0]    snoop_cmd,
    input  logic [AW-1:0] snoop_addr,
    output logic          snp_dirty,
    output logic [LW-1:0] snp_data
);
    wb_state_t     state;
    logic          load, entry_valid, hit, fire;
    logic [AW-1:0] line_addr;
    logic [LW-1:0] line_data;

    wbb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .vic_valid(vic_valid), .miss_done(miss_done),
        .bus_gnt(bus_gnt), .snp_hit(hit), .state(state), .load(load),
        .entry_valid(entry_valid), .vic_ready(vic_ready), .bus_req(bus_req),
        .wb_fire(fire)
    );

    wbb_store #(.AW(AW), .LW(LW)) u_store (
        .clk(clk), .rst_n(rst_n), .load(load), .vic_addr(vic_addr),
        .vic_data(vic_data), .line_addr(line_addr), .line_data(line_data)
    );

    wbb_snoop_cmp #(.AW(AW)) u_cmp (
        .entry_valid(entry_valid), .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd),
        .snoop_addr(snoop_addr), .line_addr(line_addr), .hit(hit)
    );

    assign wb_valid = fire;
    assign wb_addr  = line_addr;
    assign wb_data  = line_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_dirty <= 1'b0;
            snp_data  <= '0;
        end else begin
            snp_dirty <= hit;
            if (hit) snp_data <= line_data;
        end
    end
endmodule

// File: rtl/wbb_top_chk.sv
module wbb_top_chk #(
    parameter int AW = 32,
    parameter int LW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vic_valid,
    input logic [AW-1:0] vic_addr,
    input logic [LW-1:0] vic_data,
    input logic          vic_ready,
    input logic          miss_done,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          wb_valid,
    input logic [AW-1:0] wb_addr,
    input logic [LW-1:0] wb_data,
    input logic          snoop_valid,
    input logic [1:0]    snoop_cmd,
    input logic [AW-1:0] snoop_addr,
    input logic          snp_dirty,
    input logic [LW-1:0] snp_data
);
    // R2
    load_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && vic_ready) |=> !vic_ready);

    // R3
    req_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(miss_done));

    // R3
    req_excl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !vic_ready);

    // R4
    wb_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (bus_req && bus_gnt));

    // R4
    wb_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (vic_ready && !bus_req));

    // R5
    dirty_from_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |-> ($past(snoop_valid) && !$past(snoop_cmd[1]) && vic_ready));

    // R5
    dirty_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |=> !snp_dirty);

    // R8
    empty_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_ready && snoop_valid) |=> !snp_dirty);
endmodule

bind wbb_top wbb_top_chk #(.AW(AW), .LW(LW)) u_chk (.*);

// File: tb/wbb_top_test.sv
`timescale 1ns/1ps
module wbb_top_test;
    localparam int AW = 32;
    localparam int LW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          vic_valid, miss_done, bus_gnt, snoop_valid;
    logic [AW-1:0] vic_addr, snoop_addr;
    logic [LW-1:0] vic_data;
    logic [1:0]    snoop_cmd;
    logic          vic_ready, bus_req, wb_valid, snp_dirty;
    logic [AW-1:0] wb_addr;
    logic [LW-1:0] wb_data, snp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state: 0 empty, 1 parked, 2 requesting
    int            m_st;
    logic [AW-1:0] m_addr;
    logic [LW-1:0] m_data;
    logic          m_dirty;
    logic [LW-1:0] m_sdata;

    always #2.5 clk = ~clk;

    wbb_top #(.AW(AW), .LW(LW)) uut (.*);

    task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic m_hit();
        return snoop_valid && !snoop_cmd[1] && (m_st != 0) && (snoop_addr == m_addr);
    endfunction

    function automatic logic m_wb();
        return (m_st == 2) && bus_gnt && !m_hit();
    endfunction

    task automatic idle_inputs();
        vic_valid = 0; miss_done = 0; bus_gnt = 0; snoop_valid = 0;
        vic_addr = '0; vic_data = '0; snoop_addr = '0; snoop_cmd = 2'b11;
    endtask

    // inputs are already set (at negedge); check outputs, then advance one edge
    task automatic step();
        logic h;
        #1;
        chk("R2 vic_ready", LW'(vic_ready), LW'(m_st == 0));
        chk("R3 bus_req", LW'(bus_req), LW'(m_st == 2));
        chk("R4 wb_valid", LW'(wb_valid), LW'(m_wb()));
        if (m_wb()) begin
            chk("R4 wb_addr", LW'(wb_addr), LW'(m_addr));
            chk("R4 wb_data", wb_data, m_data);
        end
        chk("R5 snp_dirty", LW'(snp_dirty), LW'(m_dirty));
        if (m_dirty) chk("R5 snp_data", snp_data, m_sdata);
        h = m_hit();
        @(posedge clk);
        m_dirty = h;
        if (h) begin
            m_sdata = m_data;
            m_st = 0;
        end else begin
            case (m_st)
                0: if (vic_valid) begin m_st = 1; m_addr = vic_addr; m_data = vic_data; end
                1: if (miss_done) m_st = 2;
                2: if (bus_gnt) m_st = 0;
                default: m_st = 0;
            endcase
        end
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] pool(input int k);
        return 32'h1000_0040 + AW'(k) * 32'h40;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle_inputs();
        rst_n = 0;
        m_st = 0; m_addr = '0; m_data = '0; m_dirty = 0; m_sdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 vic_ready", LW'(vic_ready), 1);
        chk("R1 bus_req", LW'(bus_req), 0);
        chk("R1 wb_valid", LW'(wb_valid), 0);
        chk("R1 snp_dirty", LW'(snp_dirty), 0);
        rst_n = 1;

        // R2: load, then an ignored second load; R3: no req before miss_done
        vic_valid = 1; vic_addr = pool(0); vic_data = 64'hA5A5_0000_1111_2222;
        step();
        vic_addr = pool(1); vic_data = 64'hDEAD_BEEF_0000_0001;
        step(); step();
        vic_valid = 0;
        chk("R3 no req while parked", LW'(bus_req), 0);
        // R6: non-responding commands and a different address leave entry alone
        snoop_valid = 1; snoop_cmd = 2'b10; snoop_addr = pool(0); step();
        snoop_cmd = 2'b11; step();
        snoop_cmd = 2'b00; snoop_addr = pool(1); step();
        snoop_valid = 0;
        chk("R6 no response", LW'(snp_dirty), 0);
        chk("R6 entry kept", LW'(vic_ready), 0);
        miss_done = 1; step(); miss_done = 0;
        chk("R3 req after miss", LW'(bus_req), 1);
        step();
        bus_gnt = 1;
        #1;
        chk("R2 kept addr", LW'(wb_addr), LW'(pool(0)));
        chk("R2 kept data", wb_data, 64'hA5A5_0000_1111_2222);
        step(); bus_gnt = 0;
        chk("R4 freed", LW'(vic_ready), 1);

        // R5: hit while parked
        vic_valid = 1; vic_addr = pool(2); vic_data = 64'h0123_4567_89AB_CDEF;
        step(); vic_valid = 0;
        snoop_valid = 1; snoop_cmd = 2'b01; snoop_addr = pool(2);
        step(); snoop_valid = 0;
        chk("R5 dirty", LW'(snp_dirty), 1);
        chk("R5 data", snp_data, 64'h0123_4567_89AB_CDEF);
        chk("R5 dropped", LW'(vic_ready), 1);
        step();

        // R7: hit and grant in the same cycle
        vic_valid = 1; vic_addr = pool(3); vic_data = 64'hFACE_0000_CAFE_0007;
        step(); vic_valid = 0;
        miss_done = 1; step(); miss_done = 0;
        bus_gnt = 1; snoop_valid = 1; snoop_cmd = 2'b00; snoop_addr = pool(3);
        #1;
        chk("R7 wb suppressed", LW'(wb_valid), 0);
        step(); bus_gnt = 0; snoop_valid = 0;
        chk("R7 supplied", LW'(snp_dirty), 1);
        chk("R7 data", snp_data, 64'hFACE_0000_CAFE_0007);

        // R8: snoop while empty
        snoop_valid = 1; snoop_cmd = 2'b00; snoop_addr = pool(3);
        step(); snoop_valid = 0;
        chk("R8 empty silent", LW'(snp_dirty), 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            vic_valid   = ($urandom % 10) < 3;
            vic_addr    = pool(int'($urandom % 4));
            vic_data    = {$urandom, $urandom};
            miss_done   = ($urandom % 10) < 2;
            bus_gnt     = ($urandom % 10) < 3;
            snoop_valid = ($urandom % 10) < 4;
            snoop_cmd   = 2'($urandom);
            snoop_addr  = pool(int'($urandom % 4));
            step();
        end
        idle_inputs();
        step();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule